// File: doc/BRIEF.md
# Dual FIFO With Threshold Flags

This block holds the two byte queues of a packet radio data path. The host fills the transmit queue through its register interface, and the transmit engine drains it one byte per read strobe. The receive engine fills the receive queue, and the host drains it. Both queues are built from the same storage core. Each one keeps an occupancy count and shows its head byte on its read-data port ahead of the read strobe.

Each queue has two host-programmable 6-bit thresholds, one for almost full and one for almost empty. Level flags are derived from the occupancy count against these thresholds. The transmit almost-full flag is a plain comparison. The receive almost-full flag has a one-count hysteresis band.

A write to a full queue or a read from an empty queue is dropped and latches a sticky error flag. Only the synchronous reset input of the queue that caused the error clears that flag. That reset leaves the thresholds as they are.

Top module: `dual_fifo_flags`

## Requirements
- R1: After the global reset `rst_n`, both counts are 0, both almost-full flags are 0, both almost-empty flags are 1 and all error flags are 0. The threshold reset values are 54 for almost full and 4 for almost empty.
- R2: Each queue returns bytes in the order they were written. The head byte appears on the read-data port while the count is non-zero. The count rises by one per accepted write and falls by one per accepted read, and a read and a write in the same cycle leave it unchanged. Each queue holds up to 64 bytes.
- R3: A write while the count is 64 is discarded. The count and the stored data stay unchanged, and the queue's error flag is 1 from the next cycle.
- R4: A read while the count is 0 is discarded. The count stays 0, and the queue's error flag is 1 from the next cycle.
- R5: `tx_afull` is 1 exactly when the transmit count is greater than the transmit almost-full threshold.
- R6: `tx_aempty` is 1 exactly when the transmit count is less than or equal to the transmit almost-empty threshold.
- R7: `rx_afull` becomes 1 when the receive count is greater than its threshold and 0 when the count is less than it. When the count equals the threshold, the flag keeps its previous value.
- R8: An error flag stays 1 until its own queue's reset input is pulsed. A reset of the other queue leaves it at 1.
- R9: A queue reset pulse sets that queue's count to 0, clears its error flag and its hysteresis state, and empties it on the next cycle. All four thresholds keep their programmed values.
- R10: When `cfg_we` is 1, `cfg_data` is written into the threshold picked by `cfg_sel`: 0 for transmit almost full, 1 for transmit almost empty, 2 for receive almost full, 3 for receive almost empty. The flags reflect the new value on the next cycle.
- R11: `fifo_err` is 1 exactly when `tx_err` or `rx_err` is 1.
- R12: `rx_aempty` is 1 exactly when the receive count is less than or equal to the receive almost-empty threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select (0 TX AF, 1 TX AE, 2 RX AF, 3 RX AE) |
| cfg_data | input | 6 | Threshold value |
| tx_fifo_rst | input | 1 | Synchronous reset of the transmit queue |
| tx_wr | input | 1 | Host write strobe, transmit queue |
| tx_wdata | input | 8 | Host write byte |
| tx_rd | input | 1 | Transmit engine read strobe |
| tx_rdata | output | 8 | Transmit head byte |
| tx_count | output | 7 | Transmit occupancy |
| tx_afull | output | 1 | Transmit almost full |
| tx_aempty | output | 1 | Transmit almost empty |
| tx_err | output | 1 | Transmit sticky overflow/underflow |
| rx_fifo_rst | input | 1 | Synchronous reset of the receive queue |
| rx_wr | input | 1 | Receive engine write strobe |
| rx_wdata | input | 8 | Received byte |
| rx_rd | input | 1 | Host read strobe, receive queue |
| rx_rdata | output | 8 | Receive head byte |
| rx_count | output | 7 | Receive occupancy |
| rx_afull | output | 1 | Receive almost full (hysteresis) |
| rx_aempty | output | 1 | Receive almost empty |
| rx_err | output | 1 | Receive sticky overflow/underflow |
| fifo_err | output | 1 | OR of both error flags |

## Verification
A pointer or count that drifts shows at the ports within one cycle as a wrong count. It also shows as a wrong head byte at the next read, because the head byte is visible before every read strobe. A lost hysteresis state shows only while the receive count sits on its threshold, so the sweeps fill and drain each queue past every programmed threshold, including 0 and 63. A missed or stray error latch shows one cycle after the offending strobe. The bench holds the error through a reset of the other queue and then checks that the right reset clears it.

// File: rtl/dff_pkg.sv
package dff_pkg;

   typedef enum logic [1:0] {
      THR_TX_AF = 2'd0,
      THR_TX_AE = 2'd1,
      THR_RX_AF = 2'd2,
      THR_RX_AE = 2'd3
   } thr_sel_e;

   localparam int NUM_THR = 4;

endpackage

// File: rtl/dff_thr_regs.sv
module dff_thr_regs
   import dff_pkg::*;
#(
   parameter int TW     = 6,
   parameter int AF_RST = 54,
   parameter int AE_RST = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [TW-1:0] cfg_data,
   output logic [TW-1:0] tx_af_thr,
   output logic [TW-1:0] tx_ae_thr,
   output logic [TW-1:0] rx_af_thr,
   output logic [TW-1:0] rx_ae_thr
);

   logic [TW-1:0] thr_q [NUM_THR];

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      localparam logic [TW-1:0] RST_VAL =
         ((g == int'(THR_TX_AF)) || (g == int'(THR_RX_AF))) ? TW'(AF_RST) : TW'(AE_RST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q[g] <= RST_VAL;
         end else if (cfg_we && (cfg_sel == 2'(g))) begin
            thr_q[g] <= cfg_data;
         end
      end
   end

   assign tx_af_thr = thr_q[THR_TX_AF];
   assign tx_ae_thr = thr_q[THR_TX_AE];
   assign rx_af_thr = thr_q[THR_RX_AF];
   assign rx_ae_thr = thr_q[THR_RX_AE];

endmodule

// File: rtl/dff_fifo_core.sv
module dff_fifo_core #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          err
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [CW-1:0] count_q;
   logic          err_q;
   logic          wr_ok, rd_ok, bad_op;

   assign wr_ok  = wr && (count_q != CW'(DEPTH));
   assign rd_ok  = rd && (count_q != '0);
   assign bad_op = (wr && !wr_ok) || (rd && !rd_ok);

   if (DEPTH == (1 << AW)) begin : g_pow2_wrap
      assign wr_ptr_nx = wr_ptr_q + AW'(1);
      assign rd_ptr_nx = rd_ptr_q + AW'(1);
   end else begin : g_mod_wrap
      assign wr_ptr_nx = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      assign rd_ptr_nx = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (wr_ok && !clr) begin
         mem[wr_ptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         err_q    <= 1'b0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_nx;
         if (rd_ok) rd_ptr_q <= rd_ptr_nx;
         count_q <= count_q + CW'(wr_ok) - CW'(rd_ok);
         if (bad_op) err_q <= 1'b1;
      end
   end

   assign rdata = mem[rd_ptr_q];
   assign count = count_q;
   assign err   = err_q;

endmodule

// File: rtl/dff_level_flags.sv
module dff_level_flags #(
   parameter int CW      = 7,
   parameter int TW      = 6,
   parameter bit HYST_AF = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] count,
   input  logic [TW-1:0] af_thr,
   input  logic [TW-1:0] ae_thr,
   output logic          afull,
   output logic          aempty
);

   logic [CW-1:0] af_lim, ae_lim;
   logic          above_af;

   assign af_lim   = CW'(af_thr);
   assign ae_lim   = CW'(ae_thr);
   assign above_af = count > af_lim;
   assign aempty   = count <= ae_lim;

   if (HYST_AF) begin : g_hyst
      logic held_q;
      logic on_af;
      assign on_af = (count == af_lim);
      assign afull = above_af || (on_af && held_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   held_q <= 1'b0;
         else if (clr) held_q <= 1'b0;
         else          held_q <= afull;
      end
   end else begin : g_plain
      assign afull = above_af;
   end

endmodule

// File: rtl/dual_fifo_flags.sv
module dual_fifo_flags
   import dff_pkg::*;
#(
   parameter int DW     = 8,
   parameter int DEPTH  = 64,
   parameter int TW     = 6,
   parameter int AF_RST = 54,
   parameter int AE_RST = 4,
   parameter int CW     = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [TW-1:0] cfg_data,
   input  logic          tx_fifo_rst,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_wdata,
   input  logic          tx_rd,
   output logic [DW-1:0] tx_rdata,
   output logic [CW-1:0] tx_count,
   output logic          tx_afull,
   output logic          tx_aempty,
   output logic          tx_err,
   input  logic          rx_fifo_rst,
   input  logic          rx_wr,
   input  logic [DW-1:0] rx_wdata,
   input  logic          rx_rd,
   output logic [DW-1:0] rx_rdata,
   output logic [CW-1:0] rx_count,
   output logic          rx_afull,
   output logic          rx_aempty,
   output logic          rx_err,
   output logic          fifo_err
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dual_fifo_flags: DEPTH must be at least 2");
   end
   if ((1 << TW) < DEPTH) begin : g_bad_tw
      $error("dual_fifo_flags: TW too narrow to span DEPTH-1");
   end
   if (CW < $clog2(DEPTH + 1)) begin : g_bad_cw
      $error("dual_fifo_flags: CW too narrow for the count");
   end
   if ((AF_RST >= (1 << TW)) || (AE_RST >= (1 << TW))) begin : g_bad_rst
      $error("dual_fifo_flags: threshold reset value exceeds TW");
   end

   logic [TW-1:0] thr_tx_af, thr_tx_ae, thr_rx_af, thr_rx_ae;

   dff_thr_regs #(
      .TW     (TW),
      .AF_RST (AF_RST),
      .AE_RST (AE_RST)
   ) thr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_data  (cfg_data),
      .tx_af_thr (thr_tx_af),
      .tx_ae_thr (thr_tx_ae),
      .rx_af_thr (thr_rx_af),
      .rx_ae_thr (thr_rx_ae)
   );

   dff_fifo_core #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) tx_core_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_fifo_rst),
      .wr    (tx_wr),
      .wdata (tx_wdata),
      .rd    (tx_rd),
      .rdata (tx_rdata),
      .count (tx_count),
      .err   (tx_err)
   );

   dff_fifo_core #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) rx_core_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_fifo_rst),
      .wr    (rx_wr),
      .wdata (rx_wdata),
      .rd    (rx_rd),
      .rdata (rx_rdata),
      .count (rx_count),
      .err   (rx_err)
   );

   dff_level_flags #(.CW(CW), .TW(TW), .HYST_AF(1'b0)) tx_flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tx_fifo_rst),
      .count  (tx_count),
      .af_thr (thr_tx_af),
      .ae_thr (thr_tx_ae),
      .afull  (tx_afull),
      .aempty (tx_aempty)
   );

   dff_level_flags #(.CW(CW), .TW(TW), .HYST_AF(1'b1)) rx_flags_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rx_fifo_rst),
      .count  (rx_count),
      .af_thr (thr_rx_af),
      .ae_thr (thr_rx_ae),
      .afull  (rx_afull),
      .aempty (rx_aempty)
   );

   assign fifo_err = tx_err | rx_err;

endmodule

// File: rtl/dual_fifo_flags_chk.sv
module dual_fifo_flags_chk #(
   parameter int DEPTH = 64,
   parameter int TW    = 6,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_fifo_rst,
   input logic          tx_wr,
   input logic          tx_rd,
   input logic [CW-1:0] tx_count,
   input logic          tx_err,
   input logic          rx_fifo_rst,
   input logic          rx_wr,
   input logic          rx_rd,
   input logic [CW-1:0] rx_count,
   input logic          rx_err,
   input logic          rx_afull,
   input logic [TW-1:0] rx_af_thr
);

   // R2
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !tx_rd && !tx_fifo_rst && tx_count == CW'(DEPTH))
      |=> (tx_count == CW'(DEPTH) && tx_err));

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !rx_wr && !rx_fifo_rst && rx_count == '0)
      |=> (rx_count == '0 && rx_err));

   // R8
   tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_err && !tx_fifo_rst) |=> tx_err);

   // R8
   rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && !rx_fifo_rst) |=> rx_err);

   // R9
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_rst |=> (tx_count == '0 && !tx_err));

   // R9
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_rst |=> (rx_count == '0 && !rx_err && !rx_afull));

   // R7
   rx_af_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count < CW'(rx_af_thr)) |-> !rx_afull);

   // R7
   rx_af_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count > CW'(rx_af_thr)) |-> rx_afull);

endmodule

bind dual_fifo_flags dual_fifo_flags_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_fifo_rst (tx_fifo_rst),
   .tx_wr       (tx_wr),
   .tx_rd       (tx_rd),
   .tx_count    (tx_count),
   .tx_err      (tx_err),
   .rx_fifo_rst (rx_fifo_rst),
   .rx_wr       (rx_wr),
   .rx_rd       (rx_rd),
   .rx_count    (rx_count),
   .rx_err      (rx_err),
   .rx_afull    (rx_afull),
   .rx_af_thr   (thr_rx_af)
);

// File: tb/dual_fifo_flags_tb_top.sv
`timescale 1ns/1ps
module dual_fifo_flags_tb_top;

   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [5:0] cfg_data = '0;
   logic       tx_fifo_rst = 1'b0, tx_wr = 1'b0, tx_rd = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       rx_fifo_rst = 1'b0, rx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] rx_wdata = '0;
   logic [7:0] tx_rdata, rx_rdata;
   logic [6:0] tx_count, rx_count;
   logic       tx_afull, tx_aempty, tx_err, rx_afull, rx_aempty, rx_err, fifo_err;

   always #5 clk = ~clk;

   dual_fifo_flags dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .tx_fifo_rst(tx_fifo_rst), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd),
      .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_afull(tx_afull),
      .tx_aempty(tx_aempty), .tx_err(tx_err),
      .rx_fifo_rst(rx_fifo_rst), .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_afull(rx_afull),
      .rx_aempty(rx_aempty), .rx_err(rx_err), .fifo_err(fifo_err)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   int mcnt [2];
   bit maf  [2];
   bit merr [2];
   int mafthr [2];
   int maethr [2];
   logic [7:0] q_tx [$];
   logic [7:0] q_rx [$];

   task automatic chk(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      tx_wr = 0; tx_rd = 0; tx_fifo_rst = 0;
      rx_wr = 0; rx_rd = 0; rx_fifo_rst = 0;
      cfg_we = 0;
      if (mcnt[1] > mafthr[1])      maf[1] = 1'b1;
      else if (mcnt[1] < mafthr[1]) maf[1] = 1'b0;
      maf[0] = (mcnt[0] > mafthr[0]);
   endtask

   task automatic op(int f, bit w, bit r, logic [7:0] d);
      bit wok, rok;
      wok = w && (mcnt[f] < DEPTH);
      rok = r && (mcnt[f] > 0);
      if ((w && !wok) || (r && !rok)) merr[f] = 1'b1;
      if (f == 0) begin
         if (rok) void'(q_tx.pop_front());
         if (wok) q_tx.push_back(d);
         tx_wr = w; tx_rd = r; tx_wdata = d;
      end else begin
         if (rok) void'(q_rx.pop_front());
         if (wok) q_rx.push_back(d);
         rx_wr = w; rx_rd = r; rx_wdata = d;
      end
      mcnt[f] = mcnt[f] + int'(wok) - int'(rok);
      cyc();
   endtask

   task automatic frst(int f);
      mcnt[f] = 0; merr[f] = 1'b0; maf[f] = 1'b0;
      if (f == 0) begin q_tx.delete(); tx_fifo_rst = 1'b1; end
      else        begin q_rx.delete(); rx_fifo_rst = 1'b1; end
      cyc();
   endtask

   task automatic set_thr(int sel, int v);
      case (sel)
         0: mafthr[0] = v;
         1: maethr[0] = v;
         2: mafthr[1] = v;
         default: maethr[1] = v;
      endcase
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 6'(v);
      cyc();
   endtask

   task automatic chk_state(int f, string req);
      int c, af, ae, er, hd;
      if (f == 0) begin c = tx_count; af = tx_afull; ae = tx_aempty; er = tx_err; hd = tx_rdata; end
      else        begin c = rx_count; af = rx_afull; ae = rx_aempty; er = rx_err; hd = rx_rdata; end
      chk({req, " count"}, c, mcnt[f]);
      chk({req, " afull"}, af, int'(maf[f]));
      chk({req, " aempty"}, ae, int'(mcnt[f] <= maethr[f]));
      chk({req, " err"}, er, int'(merr[f]));
      chk("R11 fifo_err", fifo_err, int'(merr[0] | merr[1]));
      if (mcnt[f] > 0) begin
         if (f == 0) chk("R2 head byte", hd, q_tx[0]);
         else        chk("R2 head byte", hd, q_rx[0]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int thr_set [5] = '{0, 1, 31, 62, 63};
      for (int f = 0; f < 2; f++) begin
         mcnt[f] = 0; maf[f] = 0; merr[f] = 0; mafthr[f] = 54; maethr[f] = 4;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk_state(0, "R1");
      chk_state(1, "R1");

      for (int p = 0; p < 5; p++) begin
         for (int f = 0; f < 2; f++) begin
            string lvl;
            lvl = (f == 0) ? "R5 R6" : "R7 R12";
            set_thr(f * 2, thr_set[p]);
            set_thr(f * 2 + 1, 63 - thr_set[p]);
            frst(f);
            chk_state(f, "R9");
            for (int i = 0; i < DEPTH; i++) begin
               op(f, 1'b1, 1'b0, 8'((i * 7 + p * 13 + f * 91) & 255));
               chk_state(f, lvl);
            end
            op(f, 1'b1, 1'b0, 8'hEE);
            chk_state(f, "R3");
            frst(1 - f);
            chk_state(f, "R8");
            chk_state(1 - f, "R9");
            for (int i = 0; i < DEPTH; i++) begin
               op(f, 1'b0, 1'b1, 8'h00);
               chk_state(f, lvl);
            end
            op(f, 1'b0, 1'b1, 8'h00);
            chk_state(f, "R4");
            frst(1 - f);
            chk_state(f, "R8");
            frst(f);
            chk_state(f, "R8");
            for (int i = 0; i < 20; i++) begin
               op(f, 1'b1, 1'b0, 8'(i + 3));
               chk_state(f, "R9");
            end
            frst(f);
         end
      end

      // R10 threshold write effective next cycle, selector decode
      for (int i = 0; i < 10; i++) op(0, 1'b1, 1'b0, 8'(i + 40));
      for (int i = 0; i < 5; i++)  op(1, 1'b1, 1'b0, 8'(i + 80));
      set_thr(0, 9);
      chk_state(0, "R10"); chk_state(1, "R10");
      set_thr(0, 10);
      chk_state(0, "R10"); chk_state(1, "R10");
      set_thr(3, 4);
      chk_state(0, "R10"); chk_state(1, "R10");
      set_thr(3, 5);
      chk_state(0, "R10"); chk_state(1, "R10");
      set_thr(2, 5);
      chk_state(0, "R10"); chk_state(1, "R10");
      set_thr(1, 10);
      chk_state(0, "R10"); chk_state(1, "R10");
      // R2 simultaneous read and write
      for (int i = 0; i < 6; i++) begin
         op(0, 1'b1, 1'b1, 8'(i + 200));
         chk_state(0, "R2");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule